// File: doc/BRIEF.md
# Page Write Buffer with Commit

This block sits behind the serial front end of a byte-wide serial memory and handles the write path. The front end delivers complete bytes, plus pulses that mark where a chip-select transaction begins and ends. The end pulse comes with a flag that tells whether the transaction ended on a byte boundary. The block decodes the instruction byte and keeps the write-enable latch. For a page write it takes a two-byte start address and buffers up to one page of data bytes.

The buffered bytes reach the array only when the transaction ends cleanly: on a byte boundary, after at least one data byte. The block then runs a timed write cycle, shown as a busy flag. While the cycle runs, it streams each buffered byte to the array port and refuses array reads. When the cycle finishes, the write-enable latch clears.

A status-write instruction works in the same way. After its timed cycle it stores the protection bits. Decoding what those bits protect is left to other logic.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `status` is 0x00, `rd_block`, `rd_grant` and `arr_valid` are low, and `rx_ready` is high.
- R2: Instruction 0x06 sets the write-enable latch (status bit 1), and instruction 0x04 clears it. Either one acts only if the transaction carries exactly that one byte and `sel_aligned` is high at `sel_end`; otherwise the latch keeps its value.
- R3: A write instruction (0x02), or a status-write instruction (0x01), is ignored when the write-enable latch is clear: no busy cycle starts and no byte reaches `arr_*`.
- R4: After 0x02 come two address bytes, high byte first. The 13-bit start address is the low 13 bits of those 16, so the top three bits are don't-care. Bits [12:5] select the page and bits [4:0] the first offset. Each data byte goes to the next offset, and offset 31 is followed by offset 0 of the same page, so a later byte at the same offset replaces an earlier one. During the commit, every written offset is issued exactly once on `arr_*`, in ascending offset order, with `arr_addr` = {page, offset}. Offsets that were not written are not issued.
- R5: A write commits only when `sel_end` arrives with `sel_aligned` high after at least one data byte. Otherwise the whole write is discarded, and the write-enable latch stays set.
- R6: On commit, status bit 0 (WIP) goes high in the cycle after `sel_end` and stays high for exactly WRITE_CYCLES clocks, provided the array drain has finished. `rd_block` follows WIP.
- R7: The write-enable latch clears in the same cycle that WIP falls.
- R8: While WIP is high, every instruction except read-status (0x05) is ignored. In particular, 0x04 leaves the latch set and 0x02 issues no array writes.
- R9: Status layout: bit 0 WIP, bit 1 write-enable latch, bit 2 BP0, bit 3 BP1, bit 7 WPEN, and bits 6:4 read as zero. A committed 0x01 with data byte d runs a timed cycle, then loads BP0=d[2], BP1=d[3] and WPEN=d[7].
- R10: Once `arr_valid` is high, it stays high with `arr_addr` and `arr_data` unchanged until a cycle in which `arr_ready` is high.
- R11: A read instruction (0x03) raises `rd_grant` until `sel_end`, but only if WIP was low when the instruction byte arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_start | input | 1 | One-cycle pulse: a chip-select transaction begins |
| sel_end | input | 1 | One-cycle pulse: the transaction ends |
| sel_aligned | input | 1 | Qualifies `sel_end`: high when the end falls on a byte boundary |
| rx_valid | input | 1 | A received byte is on `rx_data` |
| rx_ready | output | 1 | Always high; the block never back-pressures the serial side |
| rx_data | input | 8 | Received byte |
| arr_valid | output | 1 | A committed byte is offered to the array |
| arr_ready | input | 1 | The array accepts the offered byte |
| arr_addr | output | ADDR_W | Array address of the offered byte |
| arr_data | output | 8 | Offered byte |
| status | output | 8 | Status register |
| rd_block | output | 1 | Array reads are refused (write cycle in progress) |
| rd_grant | output | 1 | A read transaction has been accepted |

## Verification
The assertions assume a well-formed front end. `sel_start` always comes before any byte of a transaction, `sel_end` never shares a cycle with `rx_valid` or `sel_start`, and the array eventually raises `arr_ready` so the drain completes within the write cycle. The bench drives every pulse for exactly one clock, with idle cycles between them. It throttles `arr_ready` periodically and never stalls it for long. The stimulus also covers the disallowed cases: misaligned ends, writes with no data, and instructions issued while busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INSTR,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/pwb_cmd_ctrl.sv
module pwb_cmd_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              sel_aligned,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              wip,
  input  logic              cyc_done,
  output logic              wel,
  output logic              bp0,
  output logic              bp1,
  output logic              wpen,
  output logic              rd_grant,
  output logic              ld_addr,
  output logic [ADDR_W-1:0] ld_addr_val,
  output logic              wr_byte,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic              commit_page,
  output logic              discard
);
  localparam int HI_W = ADDR_W - 8;

  phase_e          phase;
  logic [7:0]      op_q;
  logic            cmd_ok;
  logic            extra;
  logic            has_data;
  logic [HI_W-1:0] hi_q;
  logic [2:0]      sr_q;
  logic            sr_pend;
  logic            is_wr_op;
  phase_e          instr_next;
  logic            instr_ok;

  assign is_wr_op    = (op_q == OP_WRITE) || (op_q == OP_WRSR);
  assign ld_addr     = rx_valid && (phase == PH_ALO);
  assign ld_addr_val = {hi_q, rx_data};
  assign wr_byte     = rx_valid && (phase == PH_DATA) && (op_q == OP_WRITE);
  assign wr_data     = rx_data;
  assign commit      = sel_end && cmd_ok && sel_aligned && has_data
                       && is_wr_op && (phase == PH_DATA);
  assign commit_page = commit && (op_q == OP_WRITE);
  assign discard     = sel_end && cmd_ok && (op_q == OP_WRITE) && !commit;

  always_comb begin
    instr_ok   = 1'b0;
    instr_next = PH_SKIP;
    if (!wip) begin
      unique case (rx_data)
        OP_WRITE: begin
          instr_ok   = wel;
          instr_next = wel ? PH_AHI : PH_SKIP;
        end
        OP_WRSR: begin
          instr_ok   = wel;
          instr_next = wel ? PH_DATA : PH_SKIP;
        end
        OP_WREN, OP_WRDI, OP_READ: instr_ok = 1'b1;
        default: instr_ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      op_q     <= '0;
      cmd_ok   <= 1'b0;
      extra    <= 1'b0;
      has_data <= 1'b0;
      hi_q     <= '0;
      sr_q     <= '0;
      sr_pend  <= 1'b0;
      wel      <= 1'b0;
      bp0      <= 1'b0;
      bp1      <= 1'b0;
      wpen     <= 1'b0;
      rd_grant <= 1'b0;
    end else begin
      if (sel_start) begin
        phase    <= PH_INSTR;
        op_q     <= '0;
        cmd_ok   <= 1'b0;
        extra    <= 1'b0;
        has_data <= 1'b0;
        rd_grant <= 1'b0;
      end else if (sel_end) begin
        phase    <= PH_IDLE;
        cmd_ok   <= 1'b0;
        rd_grant <= 1'b0;
        if (cmd_ok && sel_aligned && !extra && phase == PH_SKIP) begin
          if (op_q == OP_WREN) wel <= 1'b1;
          if (op_q == OP_WRDI) wel <= 1'b0;
        end
        if (commit && op_q == OP_WRSR) sr_pend <= 1'b1;
      end else if (rx_valid) begin
        unique case (phase)
          PH_INSTR: begin
            op_q     <= rx_data;
            cmd_ok   <= instr_ok;
            phase    <= instr_next;
            rd_grant <= (rx_data == OP_READ) && !wip;
          end
          PH_AHI: begin
            hi_q  <= rx_data[HI_W-1:0];
            phase <= PH_ALO;
          end
          PH_ALO: phase <= PH_DATA;
          PH_DATA: begin
            has_data <= 1'b1;
            if (op_q == OP_WRSR && !has_data)
              sr_q <= {rx_data[7], rx_data[3], rx_data[2]};
          end
          PH_SKIP: extra <= 1'b1;
          default: ;
        endcase
      end
      if (cyc_done) begin
        wel     <= 1'b0;
        sr_pend <= 1'b0;
        if (sr_pend) {wpen, bp1, bp0} <= sr_q;
      end
    end
  end

  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> wel) else $error("commit without write enable"); // R3
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] ld_addr_val,
  input  logic              wr_byte,
  input  logic [7:0]        wr_data,
  input  logic              discard,
  input  logic              start_drain,
  output logic              drain_done,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  logic [7:0]            pg_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [BASE_W-1:0]     base;
  logic [OFF_W-1:0]      ptr;
  logic [OFF_W-1:0]      idx;
  logic                  drain_on;
  logic                  advance;

  assign arr_valid  = drain_on && mask[idx];
  assign advance    = drain_on && (!mask[idx] || arr_ready);
  assign arr_addr   = {base, idx};
  assign arr_data   = pg_mem[idx];
  assign drain_done = !drain_on;

  always_ff @(posedge clk) begin
    if (wr_byte) pg_mem[ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '0;
      base     <= '0;
      ptr      <= '0;
      idx      <= '0;
      drain_on <= 1'b0;
    end else begin
      if (ld_addr) begin
        base <= ld_addr_val[ADDR_W-1:OFF_W];
        ptr  <= ld_addr_val[OFF_W-1:0];
      end else if (wr_byte) begin
        ptr <= ptr + 1'b1;
      end
      if (ld_addr || discard) begin
        mask <= '0;
      end else begin
        if (wr_byte) mask[ptr] <= 1'b1;
        if (advance && mask[idx]) mask[idx] <= 1'b0;
      end
      if (start_drain) begin
        drain_on <= 1'b1;
        idx      <= '0;
      end else if (advance) begin
        idx <= idx + 1'b1;
        if (idx == LAST_OFF) drain_on <= 1'b0;
      end
    end
  end

  AST_ARR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && !arr_ready |=> arr_valid && $stable(arr_addr) && $stable(arr_data))
    else $error("array offer dropped or changed"); // R10
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic drain_done,
  output logic wip,
  output logic cyc_done
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign cyc_done = wip && (cnt == '0) && drain_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      wip <= 1'b1;
      cnt <= CNT_INIT;
    end else if (wip) begin
      if (cyc_done) wip <= 1'b0;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !wip) else $error("commit while busy"); // R8
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              sel_aligned,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic [7:0]        status,
  output logic              rd_block,
  output logic              rd_grant
);
  logic              wip, cyc_done, wel, bp0, bp1, wpen;
  logic              ld_addr, wr_byte, commit, commit_page, discard, drain_done;
  logic [ADDR_W-1:0] ld_addr_val;
  logic [7:0]        wr_data;

  assign rx_ready = 1'b1;
  assign rd_block = wip;
  assign status   = {wpen, 3'b000, bp1, bp0, wel, wip};

  pwb_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sel_start(sel_start), .sel_end(sel_end), .sel_aligned(sel_aligned),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .wip(wip), .cyc_done(cyc_done),
    .wel(wel), .bp0(bp0), .bp1(bp1), .wpen(wpen), .rd_grant(rd_grant),
    .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
    .wr_byte(wr_byte), .wr_data(wr_data),
    .commit(commit), .commit_page(commit_page), .discard(discard)
  );

  pwb_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
    .wr_byte(wr_byte), .wr_data(wr_data),
    .discard(discard), .start_drain(commit_page), .drain_done(drain_done),
    .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_addr(arr_addr), .arr_data(arr_data)
  );

  pwb_cycle_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(commit), .drain_done(drain_done),
    .wip(wip), .cyc_done(cyc_done)
  );

  AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel) else $error("latch survived write cycle"); // R7
  AST_NO_ARR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wip |-> !arr_valid) else $error("array write outside cycle"); // R4
  AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> !wip) else $error("read granted while busy"); // R11
endmodule

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
  localparam int WC = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_start = 1'b0, sel_end = 1'b0, sel_aligned = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, arr_valid, rd_block, rd_grant;
  logic        arr_ready = 1'b1;
  logic [12:0] arr_addr;
  logic [7:0]  arr_data, status;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [12:0] got_addr [512];
  logic [7:0]  got_data [512];
  int          got_n = 0;

  always #5 clk = ~clk;

  page_write_buffer #(.WRITE_CYCLES(WC)) u_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
    .sel_aligned(sel_aligned), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_addr(arr_addr), .arr_data(arr_data), .status(status),
    .rd_block(rd_block), .rd_grant(rd_grant)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    arr_ready = (cyc % 4) != 3;
    if (arr_valid && arr_ready && got_n < 512) begin
      got_addr[got_n] = arr_addr;
      got_data[got_n] = arr_data;
      got_n = got_n + 1;
    end
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_start();
    @(negedge clk); sel_start = 1'b1;
    @(negedge clk); sel_start = 1'b0;
  endtask
  task automatic t_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic t_end(input logic al);
    @(negedge clk); sel_end = 1'b1; sel_aligned = al;
    @(negedge clk); sel_end = 1'b0; sel_aligned = 1'b0;
  endtask
  task automatic t_one(input logic [7:0] op);
    t_start(); t_byte(op); t_end(1'b1);
  endtask
  task automatic t_write(input logic [15:0] a, input int n, input logic [7:0] seed, input logic al);
    t_start(); t_byte(8'h02); t_byte(a[15:8]); t_byte(a[7:0]);
    for (int i = 0; i < n; i++) t_byte(seed + 8'(i));
    t_end(al);
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (status[0] && n < 5000) begin
      if (rd_block !== 1'b1) chk("R6 rd_block", int'(rd_block), 1);
      n++;
      @(negedge clk);
    end
  endtask

  // addr[29:14], count[13:8], seed[7:0]
  localparam logic [29:0] VEC [6] = '{
    {16'h0000, 6'd1,  8'hA5},
    {16'h0045, 6'd4,  8'h10},
    {16'h1FFE, 6'd5,  8'h30},
    {16'h0120, 6'd32, 8'h80},
    {16'h0213, 6'd40, 8'h00},
    {16'hE07F, 6'd2,  8'h55}
  };

  initial begin
    int n, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", int'(status), 0);
    chk("R1 idle", int'({rd_block, rd_grant, arr_valid}), 0);
    chk("R1 rx_ready", int'(rx_ready), 1);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] a;
      int cnt, k, pop;
      logic [7:0] seed;
      logic [7:0] ed [32];
      logic [31:0] m;
      a = VEC[v][29:14]; cnt = int'(VEC[v][13:8]); seed = VEC[v][7:0];
      t_one(8'h06);
      chk("R2 wel set", int'(status[1]), 1);
      base = got_n;
      t_write(a, cnt, seed, 1'b1);
      busy_len(n);
      chk("R6 busy length", n, WC);
      chk("R7 wel cleared", int'(status[1]), 0);
      m = '0; pop = 0;
      for (int i = 0; i < cnt; i++) begin
        int off;
        off = (int'(a[4:0]) + i) % 32;
        ed[off] = seed + 8'(i);
        m[off] = 1'b1;
      end
      for (int o = 0; o < 32; o++) if (m[o]) pop++;
      chk("R4 write count", got_n - base, pop);
      k = base;
      for (int o = 0; o < 32; o++) begin
        if (m[o] && k < got_n) begin
          chk("R4 addr", int'(got_addr[k]), int'({a[12:5], 5'(o)}));
          chk("R4 data", int'(got_data[k]), int'(ed[o]));
          k++;
        end
      end
    end

    // R2 misaligned enable and single-byte rule
    t_start(); t_byte(8'h06); t_end(1'b0);
    chk("R2 misaligned wren", int'(status[1]), 0);
    t_start(); t_byte(8'h06); t_byte(8'h00); t_end(1'b1);
    chk("R2 extra byte wren", int'(status[1]), 0);

    // R3 write without latch
    base = got_n;
    t_write(16'h0040, 2, 8'h11, 1'b1);
    chk("R3 no busy", int'(status[0]), 0);
    repeat (40) @(negedge clk);
    chk("R3 no writes", got_n - base, 0);

    // R5 misaligned end and empty write
    t_one(8'h06);
    t_write(16'h0040, 3, 8'h22, 1'b0);
    chk("R5 misaligned no busy", int'(status[0]), 0);
    chk("R5 wel kept", int'(status[1]), 1);
    t_write(16'h0040, 0, 8'h22, 1'b1);
    chk("R5 empty no busy", int'(status[0]), 0);
    repeat (40) @(negedge clk);
    chk("R5 no writes", got_n - base, 0);
    t_one(8'h04);
    chk("R2 wrdi clears", int'(status[1]), 0);

    // R8 / R11 during busy
    t_one(8'h06);
    base = got_n;
    t_write(16'h0300, 2, 8'h66, 1'b1);
    chk("R6 busy started", int'(status[0]), 1);
    t_one(8'h04);
    chk("R8 wrdi ignored", int'(status[1]), 1);
    t_write(16'h0300, 4, 8'h77, 1'b1);
    t_start(); t_byte(8'h03);
    chk("R11 no grant busy", int'(rd_grant), 0);
    t_end(1'b1);
    busy_len(n);
    chk("R8 only first write", got_n - base, 2);
    t_start(); t_byte(8'h03);
    chk("R11 grant idle", int'(rd_grant), 1);
    t_end(1'b1);
    chk("R11 grant drops", int'(rd_grant), 0);

    // R9 status write
    t_one(8'h06);
    t_start(); t_byte(8'h01); t_byte(8'hFC); t_end(1'b1);
    chk("R9 during cycle", int'(status), 8'h03);
    busy_len(n);
    chk("R9 cycle length", n, WC);
    chk("R9 bits loaded", int'(status), 8'h8C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule